// File: doc/BRIEF.md
# Two-Stage Secure Watchdog

This block protects a secure execution domain from being starved of processor time by non-secure software. Secure software programs a reload value and then turns the watchdog on. From then on it must service the block periodically. If a full timeout passes without service, the block raises an interrupt, which the system routes so that it forces entry into the secure domain. If a second, equally long window then passes still without service, the block raises a security violation output to the security unit. The violation holds until reset.

Every register write carries an attribute bit that marks it secure or non-secure. Only secure writes can configure, activate or service the block. A non-secure write changes nothing except a sticky flag, which records that such a write was attempted. Once the watchdog is on, it stays on until reset, and its reload value is frozen.

Top module: `sec_wdog`

## Requirements
- R1: After reset, `irq_o`, `viol_o`, `active_o` and `ns_seen_o` are all 0.
- R2: A write with `wr_secure`=0 changes no register and no output, except that it sets `ns_seen_o`. `ns_seen_o` stays 1 until reset.
- R3: A secure write to address 0 with data bit 0 = 1, made while inactive, sets `active_o` after that clock edge and loads the counter with the reload value L. With no service, `irq_o` rises L+1 clock edges after the activating edge.
- R4: Once active, the block cannot be deactivated before reset, including by a secure write to address 0 with data bit 0 = 0.
- R5: A secure write to address 1 sets the reload value L, but only while inactive. While active, such a write has no effect on timing.
- R6: While `irq_o` is 1 and no service arrives, `viol_o` rises L+1 clock edges after the edge on which `irq_o` rose.
- R7: Once `viol_o` is 1, it stays 1 until reset, whether or not the block is serviced.
- R8: Two secure writes to address 2 on consecutive write operations, the first carrying 16'h5555 and the second 16'hAAAA, service the block. Service reloads the counter with L, clears `irq_o` on the same edge and returns the block to the first stage, so the next timeout raises `irq_o` again rather than `viol_o`.
- R9: Any other secure write between the two service values cancels the sequence. A 16'hAAAA that does not directly follow 16'h5555 does not service the block.
- R10: Address 3 is unused. A secure write to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 reload, 2 service, 3 unused |
| wr_data | input | 16 | Write data |
| wr_secure | input | 1 | 1 = write is marked secure |
| irq_o | output | 1 | First-stage timeout interrupt |
| viol_o | output | 1 | Second-stage security violation, sticky |
| active_o | output | 1 | Watchdog is running |
| ns_seen_o | output | 1 | Sticky record of a rejected non-secure write |

## Verification
The hardest state to reach is a half-finished service sequence that is cut short by an unrelated secure write. It matters because that write must still count as breaking the sequence, even though it changes no register while the block is active. The stimulus starts the watchdog, sends 16'h5555, then a secure control write that does nothing, then 16'hAAAA. It then checks that the interrupt still arrives at the time set by the original activation edge. A second test services the block only after the interrupt has fired. This shows that service returns the block to the first stage, so the next timeout raises the interrupt again and not the violation.

// File: rtl/sec_wdog_pkg.sv
package sec_wdog_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] REG_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] REG_LOAD = 2'd1;
  localparam logic [ADDR_W-1:0] REG_KICK = 2'd2;
  typedef enum logic {ST_FIRST = 1'b0, ST_SECOND = 1'b1} stage_e;
endpackage

// File: rtl/sec_wdog_gate.sv
module sec_wdog_gate (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_secure,
  output logic acc_ok,
  output logic ns_seen_q
);
  assign acc_ok = wr_en & wr_secure;

  always_ff @(posedge clk) begin
    if (rst) ns_seen_q <= 1'b0;
    else if (wr_en && !wr_secure) ns_seen_q <= 1'b1;
  end

  AST_NS_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    ns_seen_q |=> ns_seen_q); // R2
endmodule

// File: rtl/sec_wdog_keyseq.sv
module sec_wdog_keyseq
  import sec_wdog_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter logic [DW-1:0] KEY_A = 16'h5555,
  parameter logic [DW-1:0] KEY_B = 16'hAAAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_ok,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     data,
  output logic              svc_hit
);
  logic armed_q;
  logic is_a, is_b;

  assign is_a    = acc_ok && (addr == REG_KICK) && (data == KEY_A);
  assign is_b    = acc_ok && (addr == REG_KICK) && (data == KEY_B);
  assign svc_hit = armed_q && is_b;

  // Any accepted write other than the first key drops the partial sequence.
  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else if (acc_ok) armed_q <= is_a;
  end
endmodule

// File: rtl/sec_wdog_timer.sv
module sec_wdog_timer
  import sec_wdog_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter logic [DW-1:0] DEF_LOAD = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_ok,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     data,
  input  logic              svc_hit,
  output logic              active_q,
  output logic              irq_q,
  output logic              viol_q
);
  logic [DW-1:0] load_q;
  logic [DW-1:0] cnt_q;
  stage_e        stage_q;
  logic          do_arm, do_load;

  assign do_arm  = !active_q && acc_ok && (addr == REG_CTRL) && data[0];
  assign do_load = !active_q && acc_ok && (addr == REG_LOAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q   <= DEF_LOAD;
      cnt_q    <= '0;
      stage_q  <= ST_FIRST;
      active_q <= 1'b0;
      irq_q    <= 1'b0;
      viol_q   <= 1'b0;
    end else if (!active_q) begin
      if (do_load) load_q <= data;
      if (do_arm) begin
        active_q <= 1'b1;
        cnt_q    <= load_q;
        stage_q  <= ST_FIRST;
      end
    end else if (svc_hit) begin
      cnt_q   <= load_q;
      stage_q <= ST_FIRST;
      irq_q   <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q <= load_q;
      if (stage_q == ST_FIRST) begin
        irq_q   <= 1'b1;
        stage_q <= ST_SECOND;
      end else begin
        viol_q <= 1'b1;
      end
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
    active_q |=> active_q); // R4
  AST_VIOL_HOLD: assert property (@(posedge clk) disable iff (rst)
    viol_q |=> viol_q); // R7
  AST_LOAD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (active_q && $past(active_q)) |-> $stable(load_q)); // R5
  AST_IRQ_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> active_q); // R3
  AST_VIOL_AFTER_IRQ: assert property (@(posedge clk) disable iff (rst)
    $rose(viol_q) |-> $past(irq_q)); // R6
endmodule

// File: rtl/sec_wdog.sv
module sec_wdog
  import sec_wdog_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter logic [DW-1:0] KEY_A = 16'h5555,
  parameter logic [DW-1:0] KEY_B = 16'hAAAA,
  parameter logic [DW-1:0] DEF_LOAD = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              wr_secure,
  output logic              irq_o,
  output logic              viol_o,
  output logic              active_o,
  output logic              ns_seen_o
);
  logic acc_ok, svc_hit;

  sec_wdog_gate i_gate (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_secure(wr_secure),
    .acc_ok(acc_ok), .ns_seen_q(ns_seen_o)
  );

  sec_wdog_keyseq #(.DW(DW), .KEY_A(KEY_A), .KEY_B(KEY_B)) i_keyseq (
    .clk(clk), .rst(rst), .acc_ok(acc_ok), .addr(wr_addr), .data(wr_data),
    .svc_hit(svc_hit)
  );

  sec_wdog_timer #(.DW(DW), .DEF_LOAD(DEF_LOAD)) i_timer (
    .clk(clk), .rst(rst), .acc_ok(acc_ok), .addr(wr_addr), .data(wr_data),
    .svc_hit(svc_hit), .active_q(active_o), .irq_q(irq_o), .viol_q(viol_o)
  );

  AST_SVC_CLEARS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (svc_hit && active_o) |=> !irq_o); // R8
  AST_NS_NO_ARM: assert property (@(posedge clk) disable iff (rst)
    (!active_o && !(wr_en && wr_secure)) |=> !active_o); // R2
endmodule

// File: tb/test_sec_wdog.sv
module test_sec_wdog;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        wr_secure = 1'b0;
  logic        irq_o, viol_o, active_o, ns_seen_o;
  int          checks = 0;
  int          fails = 0;
  int          cyc = 0;
  int          dt;
  int          t0;

  localparam int NV = 4;
  localparam logic [15:0] VEC_LOAD [NV] = '{16'd3, 16'd0, 16'd17, 16'd40};
  localparam int          VEC_EXP  [NV] = '{4, 1, 18, 41};

  sec_wdog i_sec_wdog (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_secure(wr_secure), .irq_o(irq_o), .viol_o(viol_o),
    .active_o(active_o), .ns_seen_o(ns_seen_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic s);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_secure = s;
    @(negedge clk);
    wr_en = 1'b0; wr_secure = 1'b0;
  endtask

  task automatic kick();
    wr(2'd2, 16'h5555, 1'b1);
    wr(2'd2, 16'hAAAA, 1'b1);
  endtask

  task automatic wait_for(input bit want_viol, input int start, output int d);
    int guard = 0;
    while (!(want_viol ? viol_o : irq_o) && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    d = cyc - start;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 irq", irq_o, 0);
    chk("R1 viol", viol_o, 0);
    chk("R1 active", active_o, 0);
    chk("R1 ns_seen", ns_seen_o, 0);

    // Table walk: R3 first timeout and R6 second timeout for several loads
    for (int i = 0; i < NV; i++) begin
      do_reset();
      wr(2'd1, VEC_LOAD[i], 1'b1);
      wr(2'd0, 16'd1, 1'b1);
      t0 = cyc;
      chk("R3 active", active_o, 1);
      wait_for(1'b0, t0, dt);
      chk("R3 irq delay", dt, VEC_EXP[i]);
      chk("R6 viol before second window", viol_o, 0);
      t0 = cyc;
      wait_for(1'b1, t0, dt);
      chk("R6 viol delay", dt, VEC_EXP[i]);
    end

    // R7: violation survives service, cleared only by reset
    kick();
    chk("R7 irq cleared by service", irq_o, 0);
    chk("R7 viol held", viol_o, 1);
    repeat (60) @(negedge clk);
    chk("R7 viol still held", viol_o, 1);
    do_reset();
    chk("R7 viol cleared by reset", viol_o, 0);

    // R2: non-secure writes ignored, flag set
    do_reset();
    wr(2'd1, 16'd5, 1'b0);
    wr(2'd0, 16'd1, 1'b0);
    chk("R2 ns activate ignored", active_o, 0);
    chk("R2 ns flag", ns_seen_o, 1);
    // R10: unused address
    wr(2'd3, 16'hFFFF, 1'b1);
    chk("R10 addr3 ignored", active_o, 0);
    // R5: reload accepted while inactive, frozen once active; R4 no deactivate
    wr(2'd1, 16'd4, 1'b1);
    wr(2'd0, 16'd1, 1'b1);
    t0 = cyc;
    wr(2'd1, 16'd100, 1'b1);
    wr(2'd0, 16'd0, 1'b0);
    wr(2'd0, 16'd0, 1'b1);
    chk("R4 still active", active_o, 1);
    wr(2'd2, 16'h5555, 1'b0);
    wr(2'd2, 16'hAAAA, 1'b0);
    wait_for(1'b0, t0, dt);
    chk("R5 reload frozen and R2 ns service ignored", dt, 5);
    chk("R2 ns flag held", ns_seen_o, 1);

    // R8: service before timeout reloads
    do_reset();
    wr(2'd1, 16'd10, 1'b1);
    wr(2'd0, 16'd1, 1'b1);
    repeat (4) @(negedge clk);
    kick();
    t0 = cyc;
    chk("R8 no irq after early service", irq_o, 0);
    wait_for(1'b0, t0, dt);
    chk("R8 reload after service", dt, 11);
    // R8: service after irq returns to first stage
    kick();
    t0 = cyc;
    chk("R8 irq cleared", irq_o, 0);
    wait_for(1'b0, t0, dt);
    chk("R8 irq again after service", dt, 11);
    chk("R8 first stage, no viol", viol_o, 0);

    // R9: intervening secure write cancels the sequence
    do_reset();
    wr(2'd1, 16'd10, 1'b1);
    wr(2'd0, 16'd1, 1'b1);
    t0 = cyc;
    wr(2'd2, 16'h5555, 1'b1);
    wr(2'd0, 16'd1, 1'b1);
    wr(2'd2, 16'hAAAA, 1'b1);
    wr(2'd2, 16'hAAAA, 1'b1);
    wait_for(1'b0, t0, dt);
    chk("R9 cancelled sequence does not service", dt, 11);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule